// File: doc/BRIEF.md
# Flying-Capacitor Redundant Switch-State Selector

This block drives one phase leg of a five-level flying-capacitor converter. A current-band controller upstream asks for an output level from 0 to 4, which is the number of upper switches that are on. Most levels can be built from several upper-switch patterns, and each pattern charges, discharges or leaves alone each of the three flying capacitors. The lower switches are the complements of the upper ones, so this block only selects the four upper switch states.

Each capacitor has a pair of comparator outputs that say whether its voltage is above or below its target. These needs are captured on a fixed-period sampling tick, so the block picks a new pattern at every tick even while the level is held. The current sign reverses the effect each pattern has on the capacitors. Every legal pattern gets a score, and the pattern that best matches the recorded needs wins. Ties are settled by the fewest switch transitions, so the switches toggle as little as possible. A change of the requested level triggers a new selection at once, using the needs captured at the last tick.

Top module: `fcsel_state_selector`

## Requirements
- R1: When `valid_o` is high, the number of ones in `sw_o` equals the level that was requested in the previous cycle.
- R2: Level 0 always gives `sw_o`=0000 and level 4 always gives 1111, whatever the capacitor needs are.
- R3: For each capacitor k, `err_pos_i[k]`=1 alone requests discharge, `err_neg_i[k]`=1 alone requests charge, and both low or both high request nothing.
- R4: Switch bit k-1 is S_k, and capacitor k (k=1..3) sits between bit k-1 and bit k. With `cur_neg_i`=0, the capacitor charges when bit k=1 and bit k-1=0, and discharges when bit k=0 and bit k-1=1. With `cur_neg_i`=1, both effects swap.
- R5: A pattern's score is the number of capacitors moved in their requested direction minus the number moved against it. The legal pattern with the highest score is chosen.
- R6: Among patterns with equal score, the one with the fewest bits different from the present `sw_o` wins. If that is still tied, the lowest binary code wins.
- R7: Capacitor needs are captured only in a cycle with `tick_i`=1. A selection made on a tick uses the live comparator inputs, and comparator changes between ticks alter nothing.
- R8: A legal level that differs from the last accepted level starts a selection in that cycle, without a tick, using the needs captured at the last tick.
- R9: When no selection occurs, `sw_o` holds its value and `valid_o` is low.
- R10: A level code above 4 is ignored. It causes no selection, `sw_o` does not change, and the last accepted level is kept.
- R11: Reset gives `sw_o`=0000, `valid_o`=0, a stored level of 0, and no capacitor needs.
- R12: A selection updates `sw_o` at the next clock edge and raises `valid_o` for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sampling tick for the capacitor needs |
| level_i | input | 3 | Requested output level, 0..4 |
| cur_neg_i | input | 1 | Output current sign, 1 = negative |
| err_pos_i | input | 3 | Per capacitor: voltage above target |
| err_neg_i | input | 3 | Per capacitor: voltage below target |
| sw_o | output | 4 | Upper switch states, bit k-1 = S_k |
| valid_o | output | 1 | One-cycle strobe after each selection |

## Verification
The bench sets up cases where a single hidden mistake changes the result. It reverses the current sign on a fixed set of needs, so a design that ignores the sign keeps the pattern for positive current. It gives ties that are broken by transition count, and the tie from reset, so a design that skips the distance rule or scans from the top picks a different code. It changes the comparator inputs between ticks and then changes the level, so a design that reads the live comparators picks a pattern for the wrong needs. It also sends illegal level codes followed by the old level again. A design that records an illegal level reselects when the old level returns, and a design that acts on the illegal code emits a stray strobe.

// File: rtl/fcsel_pkg.sv
package fcsel_pkg;

   // Need and effect share one encoding so that a match is an equality test.
   localparam logic [1:0] NEED_NONE = 2'b00;
   localparam logic [1:0] NEED_CHG  = 2'b01;
   localparam logic [1:0] NEED_DIS  = 2'b10;

   // Effect on the capacitor between switch "below" and switch "above".
   function automatic logic [1:0] cap_effect(input logic below,
                                             input logic above,
                                             input logic neg);
      logic [1:0] e;
      e = NEED_NONE;
      if (above && !below)
         e = neg ? NEED_DIS : NEED_CHG;
      else if (!above && below)
         e = neg ? NEED_CHG : NEED_DIS;
      return e;
   endfunction

   function automatic logic [1:0] need_code(input logic hi_err, input logic lo_err);
      logic [1:0] n;
      case ({hi_err, lo_err})
         2'b10:   n = NEED_DIS;
         2'b01:   n = NEED_CHG;
         default: n = NEED_NONE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/fcsel_need_sampler.sv
module fcsel_need_sampler
   import fcsel_pkg::*;
#(
   parameter int NUM_CAP = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    tick_i,
   input  logic [NUM_CAP-1:0]      err_pos_i,
   input  logic [NUM_CAP-1:0]      err_neg_i,
   output logic [NUM_CAP-1:0][1:0] need_o
);

   logic [NUM_CAP-1:0][1:0] live_need;
   logic [NUM_CAP-1:0][1:0] held_need;

   for (genvar k = 0; k < NUM_CAP; k++) begin : g_code
      assign live_need[k] = need_code(err_pos_i[k], err_neg_i[k]);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)
         held_need <= '0;
      else if (tick_i)
         held_need <= live_need;
   end

   // On a tick the fresh needs are used in the same cycle they are captured.
   assign need_o = tick_i ? live_need : held_need;

endmodule

// File: rtl/fcsel_cand_eval.sv
module fcsel_cand_eval
   import fcsel_pkg::*;
#(
   parameter  int NUM_SW  = 4,
   parameter  int CODE    = 0,
   localparam int NUM_CAP = NUM_SW - 1,
   localparam int LW      = $clog2(NUM_SW + 1),
   localparam int SCW     = $clog2(NUM_CAP + 1) + 1
) (
   input  logic [NUM_CAP-1:0][1:0] need_i,
   input  logic                    cur_neg_i,
   input  logic [NUM_SW-1:0]       present_i,
   output logic signed [SCW-1:0]   score_o,
   output logic [LW-1:0]           dist_o,
   output logic [LW-1:0]           level_o
);

   localparam logic [NUM_SW-1:0]     PAT = NUM_SW'(CODE);
   localparam logic signed [SCW-1:0] ONE = SCW'(1);

   always_comb begin
      logic signed [SCW-1:0] acc;
      acc = '0;
      for (int k = 0; k < NUM_CAP; k++) begin
         logic [1:0] eff;
         eff = cap_effect(PAT[k], PAT[k+1], cur_neg_i);
         if (need_i[k] != NEED_NONE && eff != NEED_NONE) begin
            if (eff == need_i[k])
               acc = acc + ONE;
            else
               acc = acc - ONE;
         end
      end
      score_o = acc;
   end

   assign dist_o  = LW'($countones(PAT ^ present_i));
   assign level_o = LW'($countones(PAT));

endmodule

// File: rtl/fcsel_pick.sv
module fcsel_pick #(
   parameter  int NUM_SW  = 4,
   localparam int NCAND   = 1 << NUM_SW,
   localparam int NUM_CAP = NUM_SW - 1,
   localparam int LW      = $clog2(NUM_SW + 1),
   localparam int SCW     = $clog2(NUM_CAP + 1) + 1
) (
   input  logic [LW-1:0]              target_i,
   input  logic [NCAND-1:0][LW-1:0]   lvl_i,
   input  logic [NCAND-1:0][SCW-1:0]  score_i,
   input  logic [NCAND-1:0][LW-1:0]   dist_i,
   output logic [NUM_SW-1:0]          best_o,
   output logic                       found_o
);

   // Linear scan with strict improvement: lowest code wins the last tie.
   always_comb begin
      logic signed [SCW-1:0] bs;
      logic [LW-1:0]         bd;
      found_o = 1'b0;
      best_o  = '0;
      bs      = '0;
      bd      = '0;
      for (int i = 0; i < NCAND; i++) begin
         if (lvl_i[i] == target_i) begin
            if (!found_o || $signed(score_i[i]) > bs ||
                ($signed(score_i[i]) == bs && dist_i[i] < bd)) begin
               found_o = 1'b1;
               best_o  = NUM_SW'(i);
               bs      = $signed(score_i[i]);
               bd      = dist_i[i];
            end
         end
      end
   end

endmodule

// File: rtl/fcsel_state_selector.sv
module fcsel_state_selector #(
   parameter  int NUM_SW  = 4,
   localparam int NUM_CAP = NUM_SW - 1,
   localparam int LW      = $clog2(NUM_SW + 1)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               tick_i,
   input  logic [LW-1:0]      level_i,
   input  logic               cur_neg_i,
   input  logic [NUM_CAP-1:0] err_pos_i,
   input  logic [NUM_CAP-1:0] err_neg_i,
   output logic [NUM_SW-1:0]  sw_o,
   output logic               valid_o
);

   localparam int            NCAND   = 1 << NUM_SW;
   localparam int            SCW     = $clog2(NUM_CAP + 1) + 1;
   localparam logic [LW-1:0] MAX_LVL = LW'(NUM_SW);

   if (NUM_SW < 2 || NUM_SW > 6) begin : g_bad_cfg
      $error("fcsel_state_selector: NUM_SW must lie in 2..6");
   end

   logic [NUM_CAP-1:0][1:0]  need;
   logic [NCAND-1:0][LW-1:0] cand_lvl;
   logic [NCAND-1:0][SCW-1:0] cand_score;
   logic [NCAND-1:0][LW-1:0] cand_dist;
   logic [NUM_SW-1:0]        best;
   logic                     found;
   logic [NUM_SW-1:0]        sw_q;
   logic [LW-1:0]            lvl_q;
   logic                     valid_q;
   logic                     legal;
   logic                     resel;

   fcsel_need_sampler #(.NUM_CAP(NUM_CAP)) u_need (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .tick_i    (tick_i),
      .err_pos_i (err_pos_i),
      .err_neg_i (err_neg_i),
      .need_o    (need)
   );

   for (genvar c = 0; c < NCAND; c++) begin : g_cand
      logic signed [SCW-1:0] sc;
      fcsel_cand_eval #(.NUM_SW(NUM_SW), .CODE(c)) u_eval (
         .need_i    (need),
         .cur_neg_i (cur_neg_i),
         .present_i (sw_q),
         .score_o   (sc),
         .dist_o    (cand_dist[c]),
         .level_o   (cand_lvl[c])
      );
      assign cand_score[c] = sc;
   end

   fcsel_pick #(.NUM_SW(NUM_SW)) u_pick (
      .target_i (level_i),
      .lvl_i    (cand_lvl),
      .score_i  (cand_score),
      .dist_i   (cand_dist),
      .best_o   (best),
      .found_o  (found)
   );

   assign legal = (level_i <= MAX_LVL);
   assign resel = legal && found && (tick_i || level_i != lvl_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sw_q    <= '0;
         lvl_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= resel;
         if (resel) begin
            sw_q  <= best;
            lvl_q <= level_i;
         end
      end
   end

   assign sw_o    = sw_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/fcsel_state_selector_chk.sv
module fcsel_state_selector_chk #(
   parameter  int NUM_SW = 4,
   localparam int LW     = $clog2(NUM_SW + 1)
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              tick_i,
   input logic [LW-1:0]     level_i,
   input logic [NUM_SW-1:0] sw_o,
   input logic              valid_o
);

   localparam logic [LW-1:0] MAX_LVL = LW'(NUM_SW);

   p_level_popcount_r1: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> ($countones(sw_o) == int'($past(level_i))));

   p_extreme_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && $past(level_i) == '0) |-> (sw_o == '0));

   p_extreme_high_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && $past(level_i) == MAX_LVL) |-> (&sw_o));

   p_tick_reselects_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_i && level_i <= MAX_LVL) |=> valid_o);

   p_level_change_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!$past(rst_i) && $past(level_i) <= MAX_LVL && level_i <= MAX_LVL &&
       level_i != $past(level_i)) |=> valid_o);

   p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_o |-> $stable(sw_o));

   p_illegal_ignored_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (level_i > MAX_LVL) |=> !valid_o);

endmodule

bind fcsel_state_selector fcsel_state_selector_chk #(.NUM_SW(NUM_SW)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .tick_i  (tick_i),
   .level_i (level_i),
   .sw_o    (sw_o),
   .valid_o (valid_o)
);

// File: tb/fcsel_state_selector_tb.sv
`timescale 1ns/1ps
module fcsel_state_selector_tb_top;

   logic       clk = 1'b0;
   logic       rst_i = 1'b1;
   logic       tick_i = 1'b0;
   logic [2:0] level_i = '0;
   logic       cur_neg_i = 1'b0;
   logic [2:0] err_pos_i = '0;
   logic [2:0] err_neg_i = '0;
   logic [3:0] sw_o;
   logic       valid_o;

   always #4 clk = ~clk;

   fcsel_state_selector dut_i (
      .clk_i     (clk),
      .rst_i     (rst_i),
      .tick_i    (tick_i),
      .level_i   (level_i),
      .cur_neg_i (cur_neg_i),
      .err_pos_i (err_pos_i),
      .err_neg_i (err_neg_i),
      .sw_o      (sw_o),
      .valid_o   (valid_o)
   );

   typedef struct {
      logic [3:0] code;
      string      tag;
   } exp_t;

   exp_t       q[$];
   int         n_checks = 0;
   int         n_errors = 0;
   bit         done = 0;
   bit         mon_on = 0;
   logic [3:0] m_sw = '0;
   int         m_lvl = 0;
   logic [2:0] m_dis = '0;
   logic [2:0] m_chg = '0;

   task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // Reference selection computed from the written rules (R3..R6).
   function automatic logic [3:0] model_pick(input int lvl, input logic [2:0] dis,
                                             input logic [2:0] chg, input logic neg,
                                             input logic [3:0] pres);
      int         best_s;
      int         best_d;
      logic [3:0] best;
      best_s = -99;
      best_d = 99;
      best = '0;
      for (int c = 0; c < 16; c++) begin
         logic [3:0] p;
         int s;
         int d;
         p = c[3:0];
         s = 0;
         if ($countones(p) == lvl) begin
            for (int k = 0; k < 3; k++) begin
               int e;
               int want;
               e = 0;
               if (p[k+1] && !p[k]) e = 1;
               else if (!p[k+1] && p[k]) e = -1;
               if (neg) e = -e;
               want = (chg[k] && !dis[k]) ? 1 : ((dis[k] && !chg[k]) ? -1 : 0);
               if (want != 0 && e != 0) s += (want == e) ? 1 : -1;
            end
            d = $countones(p ^ pres);
            if (s > best_s || (s == best_s && d < best_d)) begin
               best_s = s;
               best_d = d;
               best = p;
            end
         end
      end
      return best;
   endfunction

   task automatic apply(input int lvl, input logic [2:0] dis, input logic [2:0] chg,
                        input logic neg, input logic tk, input int hand, input string tag);
      logic [2:0] nd;
      logic [2:0] nc;
      exp_t       e;
      @(negedge clk);
      level_i = lvl[2:0];
      err_pos_i = dis;
      err_neg_i = chg;
      cur_neg_i = neg;
      tick_i = tk;
      nd = tk ? dis : m_dis;
      nc = tk ? chg : m_chg;
      if (tk) begin
         m_dis = dis;
         m_chg = chg;
      end
      if (lvl <= 4 && (tk || lvl != m_lvl)) begin
         e.code = (hand >= 0) ? hand[3:0] : model_pick(lvl, nd, nc, neg, m_sw);
         e.tag = tag;
         q.push_back(e);
         m_sw = e.code;
         m_lvl = lvl;
      end
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   // Monitor: compares each strobe with the scoreboard, checks hold otherwise.
   initial begin
      logic [3:0] last_sw;
      exp_t       e;
      last_sw = '0;
      forever begin
         @(posedge clk);
         #1;
         if (mon_on) begin
            if (valid_o) begin
               if (q.size() == 0) begin
                  n_checks++;
                  n_errors++;
                  $display("FAIL R12 unexpected strobe: got sw %b expected no strobe", sw_o);
               end else begin
                  e = q.pop_front();
                  check(sw_o, e.code, e.tag);
               end
            end else if (sw_o !== last_sw) begin
               n_checks++;
               n_errors++;
               $display("FAIL R9 hold: got %b expected %b", sw_o, last_sw);
            end
         end
         last_sw = sw_o;
      end
   end

   task automatic report;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

   initial begin
      int unsigned r;
      repeat (4) @(negedge clk);
      rst_i = 1'b0;
      @(posedge clk);
      #1;
      check(sw_o, 4'b0000, "R11 reset switches");
      check({3'b000, valid_o}, 4'b0000, "R11 reset strobe");
      mon_on = 1;

      // Ties from 0000 at level 1: all at distance 1, lowest code.
      apply(1, 3'b000, 3'b000, 1'b0, 1'b0, 4'b0001, "R6 lowest code tie");
      // Need discharge/charge/discharge: 0101 satisfies all three.
      apply(2, 3'b101, 3'b010, 1'b0, 1'b1, 4'b0101, "R5 full match");
      // Same needs, negative current: effects flip, 1010 wins.
      apply(2, 3'b101, 3'b010, 1'b1, 1'b1, 4'b1010, "R4 current sign");
      apply(0, 3'b111, 3'b000, 1'b0, 1'b1, 4'b0000, "R2 level zero");
      apply(4, 3'b010, 3'b101, 1'b0, 1'b1, 4'b1111, "R2 level four");
      // Both comparator bits high means no need: all tie at distance 1.
      apply(3, 3'b111, 3'b111, 1'b0, 1'b1, 4'b0111, "R3 both bits no need");
      // Capacitor 3 wants charge: 1011 is the only positive score.
      apply(3, 3'b000, 3'b100, 1'b0, 1'b1, 4'b1011, "R5 single need");
      // Comparators change without a tick: nothing happens.
      apply(3, 3'b100, 3'b000, 1'b0, 1'b0, -1, "R7 no tick");
      @(posedge clk);
      #1;
      check(sw_o, 4'b1011, "R7 held without tick");
      // Level change uses the stored charge need: 1001 and 1010 tie, 1001 lower.
      apply(2, 3'b100, 3'b000, 1'b0, 1'b0, 4'b1001, "R8 level change stored needs");
      apply(6, 3'b000, 3'b000, 1'b0, 1'b1, -1, "R10 illegal level");
      @(posedge clk);
      #1;
      check(sw_o, 4'b1001, "R10 illegal level held");
      apply(2, 3'b000, 3'b000, 1'b0, 1'b0, -1, "R10 level kept");
      @(posedge clk);
      #1;
      check(sw_o, 4'b1001, "R10 stored level kept");

      r = 32'h1234_5678;
      for (int i = 0; i < 60; i++) begin
         r = r * 1103515245 + 12345;
         apply(int'(r[18:16]), r[22:20], r[26:24], r[28], r[30], -1, "R1/R5/R6 mixed");
      end

      repeat (4) @(posedge clk);
      #1;
      n_checks++;
      if (q.size() != 0) begin
         n_errors++;
         $display("FAIL R12 missing strobes: got %0d pending expected 0", q.size());
      end
      done = 1;
      report();
   end

endmodule